// File: doc/BRIEF.md
# Tagged-Kernel Convolution Weight Chain

This block is a row of compute cores joined in a single shift chain. Feature vectors and kernel weight words enter at the head of the chain and advance one core per clock. Each kernel word carries a tag. A core keeps a word only when the tag equals its own position, so core n ends up holding kernel n. Each core works out the signed dot product of every feature vector that passes it with the kernel it currently uses. The per-core results are re-timed so that all of them for the same feature vector leave the block in one cycle, as one wide word.

Every core holds two weight banks. The active bank serves the batch now running. The shadow bank takes the kernel words of the next batch. A batch-start pulse asks for the banks to trade roles. The trade is granted only once every core's shadow bank holds all of its elements. It then travels down the chain as a marker, in step with the feature stream. Feature vectors that entered before the marker use the old kernels, and those that entered with it or after it use the new ones. A request made while any shadow bank is incomplete raises a stall flag. The request then waits and completes on its own when the last missing word lands.

Top module: `conv_weight_chain`

## Requirements
- R1: After reset `stall` and `res_valid` are 0 and both banks of every core hold zeros, so a feature vector sent before any swap yields 0 from every core.
- R2: A kernel word with `kv_valid`=1 is written only into the core whose index equals `kv_tag`, at element `kv_idx`. Core n's result sits at `res_data[n*ACC_W +: ACC_W]`, and feature element i sits at `fm_data[i*DATA_W +: DATA_W]`.
- R3: Each core's result is the signed sum over i of feature element i times kernel element i, held in ACC_W = 2*DATA_W + clog2(VEC_LEN) bits with no wrap. With the defaults, four products of -128 by -128 give +65536 and four of 127 by -128 give -65024.
- R4: A feature vector sampled on a clock edge gives `res_valid`=1 with all NUM_CORES results after exactly NUM_CORES further edges. `res_valid` stays 0 one edge earlier. Back-to-back features give back-to-back results in order.
- R5: Kernel words go into the shadow bank only. Results keep using the active kernels until a swap reaches the core.
- R6: A `batch_start` sampled while every core's shadow bank is complete is granted at once and leaves `stall` at 0. A feature vector sampled in the same cycle as the granted pulse, or later, uses the new kernels. One sampled a cycle earlier uses the old kernels.
- R7: A `batch_start` sampled while any shadow bank is incomplete sets `stall` to 1 from the next cycle. `stall` holds while loading is incomplete. Once the last element is written, the swap is granted without a further pulse and `stall` returns to 0.
- R8: A feature vector and a kernel word presented in the same cycle are both handled. The feature gets its result, and the word counts toward filling the shadow bank.
- R9: A granted swap empties every shadow bank's fill state. A new `batch_start` without a full reload stalls and leaves the active kernels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fm_valid | input | 1 | Feature vector present this cycle |
| fm_data | input | VEC_LEN*DATA_W | Feature vector, element i at bits i*DATA_W, signed |
| kv_valid | input | 1 | Kernel word present this cycle |
| kv_tag | input | clog2(NUM_CORES) | Index of the core that should keep the word |
| kv_idx | input | clog2(VEC_LEN) | Element position of the word in the kernel |
| kv_data | input | DATA_W | Kernel word, signed |
| batch_start | input | 1 | One-cycle request to swap active and shadow banks |
| stall | output | 1 | A swap request is waiting for incomplete shadow banks |
| res_valid | output | 1 | Results for one feature vector are present |
| res_data | output | NUM_CORES*ACC_W | Per-core signed results, core n at bits n*ACC_W |

## Verification
If a core's tag comparison or element index goes wrong, exactly that core's result slice is off for every later feature. The first feature after the swap shows it, NUM_CORES+1 edges after it enters. A swap that fires too early or leaves a core's fill state stale shows up as a `stall` level wrong by the next cycle. It also shows as one feature vector computed against the wrong batch's kernels at the output. Probing features placed on both sides of the batch-start pulse pin the boundary to a single cycle. A hop or alignment stage of the wrong depth moves `res_valid` off its exact edge and splits the results of one vector across two output cycles.

// File: rtl/wcd_pkg.sv
package wcd_pkg;

  // Width of a signed dot-product accumulator that cannot wrap over len terms.
  function automatic int acc_width(input int dw, input int len);
    return 2 * dw + $clog2(len);
  endfunction

  // Width of an index able to address n items, never narrower than one bit.
  function automatic int index_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wcd_hop.sv
// One register stage of the chain: carries feature, kernel word and swap marker.
module wcd_hop #(
  parameter int FM_W  = 32,
  parameter int TAG_W = 2,
  parameter int IDX_W = 2,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_fm_v,
  input  logic [FM_W-1:0]  i_fm_d,
  input  logic             i_kv_v,
  input  logic [TAG_W-1:0] i_kv_tag,
  input  logic [IDX_W-1:0] i_kv_idx,
  input  logic [DW-1:0]    i_kv_d,
  input  logic             i_tok,
  output logic             o_fm_v,
  output logic [FM_W-1:0]  o_fm_d,
  output logic             o_kv_v,
  output logic [TAG_W-1:0] o_kv_tag,
  output logic [IDX_W-1:0] o_kv_idx,
  output logic [DW-1:0]    o_kv_d,
  output logic             o_tok
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_fm_v   <= 1'b0;
      o_fm_d   <= '0;
      o_kv_v   <= 1'b0;
      o_kv_tag <= '0;
      o_kv_idx <= '0;
      o_kv_d   <= '0;
      o_tok    <= 1'b0;
    end else begin
      o_fm_v   <= i_fm_v;
      o_fm_d   <= i_fm_d;
      o_kv_v   <= i_kv_v;
      o_kv_tag <= i_kv_tag;
      o_kv_idx <= i_kv_idx;
      o_kv_d   <= i_kv_d;
      o_tok    <= i_tok;
    end
  end

endmodule

// File: rtl/wcd_core.sv
// Compute core: two weight banks, tag capture into the shadow bank, dot product.
module wcd_core #(
  parameter int IDX   = 0,
  parameter int LEN   = 4,
  parameter int DW    = 8,
  parameter int ACC_W = 18,
  parameter int TAG_W = 2,
  parameter int IDX_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fm_v,
  input  logic [LEN*DW-1:0]       fm_d,
  input  logic                    kv_v,
  input  logic [TAG_W-1:0]        kv_tag,
  input  logic [IDX_W-1:0]        kv_idx,
  input  logic [DW-1:0]           kv_d,
  input  logic                    tok,
  output logic                    res_v,
  output logic signed [ACC_W-1:0] res_d,
  output logic                    sel_o,
  output logic                    full_o
);

  localparam int PW = 2 * DW;

  logic signed [DW-1:0] bank [2][LEN];
  logic                 sel_q;
  logic [LEN-1:0]       fill_q;
  logic                 eff_sel;
  logic                 wr_hit;
  logic [LEN-1:0]       wr_mask;
  logic signed [DW-1:0] act_w [LEN];

  // Signed dot product of a packed feature vector with one kernel.
  function automatic logic signed [ACC_W-1:0] dot_prod(
    input logic [LEN*DW-1:0]  f,
    input logic signed [DW-1:0] w [LEN]
  );
    logic signed [ACC_W-1:0] acc;
    logic signed [DW-1:0]    fe;
    logic signed [PW-1:0]    a;
    logic signed [PW-1:0]    b;
    logic signed [PW-1:0]    p;
    acc = '0;
    for (int i = 0; i < LEN; i++) begin
      fe  = f[i*DW +: DW];
      a   = PW'(fe);
      b   = PW'(w[i]);
      p   = a * b;
      acc = acc + ACC_W'(p);
    end
    return acc;
  endfunction

  // The swap marker takes effect for the feature it travels with.
  assign eff_sel = sel_q ^ tok;
  assign wr_hit  = kv_v && (kv_tag == TAG_W'(IDX));
  assign wr_mask = LEN'(1) << kv_idx;

  always_comb begin
    for (int i = 0; i < LEN; i++) act_w[i] = bank[eff_sel][i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b2 = 0; b2 < 2; b2++)
        for (int i = 0; i < LEN; i++) bank[b2][i] <= '0;
    end else if (wr_hit) begin
      bank[~eff_sel][kv_idx] <= kv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      fill_q <= '0;
    end else begin
      sel_q <= eff_sel;
      if (tok) fill_q <= wr_hit ? wr_mask : '0;
      else if (wr_hit) fill_q <= fill_q | wr_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_v <= 1'b0;
      res_d <= '0;
    end else begin
      res_v <= fm_v;
      if (fm_v) res_d <= dot_prod(fm_d, act_w);
    end
  end

  assign sel_o  = sel_q;
  assign full_o = &fill_q;

endmodule

// File: rtl/wcd_align.sv
// Delay line that lines a core's result up with the last core's result.
module wcd_align #(
  parameter int DEPTH = 0,
  parameter int W     = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);

  generate
    if (DEPTH == 0) begin : g_pass
      assign out_v = in_v;
      assign out_d = in_d;
    end else begin : g_delay
      logic [W:0] sh [DEPTH];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int k = 0; k < DEPTH; k++) sh[k] <= '0;
        end else begin
          sh[0] <= {in_v, in_d};
          for (int k = 1; k < DEPTH; k++) sh[k] <= sh[k-1];
        end
      end
      assign out_v = sh[DEPTH-1][W];
      assign out_d = sh[DEPTH-1][W-1:0];
    end
  endgenerate

endmodule

// File: rtl/wcd_swap_ctrl.sv
// Grants swap requests once every shadow bank is complete and no marker travels.
module wcd_swap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic batch_start,
  input  logic all_full,
  input  logic in_flight,
  output logic issue,
  output logic stall
);

  logic pend_q;
  logic req;

  assign req   = batch_start | pend_q;
  assign issue = req & all_full & ~in_flight;
  assign stall = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= req & ~issue;
  end

endmodule

// File: rtl/conv_weight_chain.sv
module conv_weight_chain #(
  parameter int NUM_CORES = 4,
  parameter int VEC_LEN   = 4,
  parameter int DATA_W    = 8,
  localparam int ACC_W    = wcd_pkg::acc_width(DATA_W, VEC_LEN),
  localparam int TAG_W    = wcd_pkg::index_width(NUM_CORES),
  localparam int IDX_W    = wcd_pkg::index_width(VEC_LEN),
  localparam int FM_W     = VEC_LEN * DATA_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fm_valid,
  input  logic [FM_W-1:0]            fm_data,
  input  logic                       kv_valid,
  input  logic [TAG_W-1:0]           kv_tag,
  input  logic [IDX_W-1:0]           kv_idx,
  input  logic [DATA_W-1:0]          kv_data,
  input  logic                       batch_start,
  output logic                       stall,
  output logic                       res_valid,
  output logic [NUM_CORES*ACC_W-1:0] res_data
);

  logic             h_fm_v   [NUM_CORES];
  logic [FM_W-1:0]  h_fm_d   [NUM_CORES];
  logic             h_kv_v   [NUM_CORES];
  logic [TAG_W-1:0] h_kv_tag [NUM_CORES];
  logic [IDX_W-1:0] h_kv_idx [NUM_CORES];
  logic [DATA_W-1:0] h_kv_d  [NUM_CORES];

  logic             c_res_v  [NUM_CORES];
  logic [ACC_W-1:0] c_res_d  [NUM_CORES];
  logic             a_res_v  [NUM_CORES];

  // Named internal events for the checker.
  logic [NUM_CORES-1:0] swap_at;
  logic [NUM_CORES-1:0] core_sel;
  logic [NUM_CORES-1:0] core_full;
  logic                 all_full;
  logic                 swap_issue;
  logic                 tail_fm_valid;

  assign all_full      = &core_full;
  assign tail_fm_valid = h_fm_v[NUM_CORES-1];

  wcd_swap_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .batch_start (batch_start),
    .all_full    (all_full),
    .in_flight   (|swap_at),
    .issue       (swap_issue),
    .stall       (stall)
  );

  generate
    for (genvar n = 0; n < NUM_CORES; n++) begin : g_core
      if (n == 0) begin : g_head
        wcd_hop #(.FM_W(FM_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .DW(DATA_W)) u_hop (
          .clk (clk), .rst_n (rst_n),
          .i_fm_v (fm_valid), .i_fm_d (fm_data),
          .i_kv_v (kv_valid), .i_kv_tag (kv_tag), .i_kv_idx (kv_idx), .i_kv_d (kv_data),
          .i_tok (swap_issue),
          .o_fm_v (h_fm_v[n]), .o_fm_d (h_fm_d[n]),
          .o_kv_v (h_kv_v[n]), .o_kv_tag (h_kv_tag[n]), .o_kv_idx (h_kv_idx[n]),
          .o_kv_d (h_kv_d[n]), .o_tok (swap_at[n])
        );
      end else begin : g_link
        wcd_hop #(.FM_W(FM_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .DW(DATA_W)) u_hop (
          .clk (clk), .rst_n (rst_n),
          .i_fm_v (h_fm_v[n-1]), .i_fm_d (h_fm_d[n-1]),
          .i_kv_v (h_kv_v[n-1]), .i_kv_tag (h_kv_tag[n-1]), .i_kv_idx (h_kv_idx[n-1]),
          .i_kv_d (h_kv_d[n-1]), .i_tok (swap_at[n-1]),
          .o_fm_v (h_fm_v[n]), .o_fm_d (h_fm_d[n]),
          .o_kv_v (h_kv_v[n]), .o_kv_tag (h_kv_tag[n]), .o_kv_idx (h_kv_idx[n]),
          .o_kv_d (h_kv_d[n]), .o_tok (swap_at[n])
        );
      end

      wcd_core #(
        .IDX (n), .LEN (VEC_LEN), .DW (DATA_W), .ACC_W (ACC_W),
        .TAG_W (TAG_W), .IDX_W (IDX_W)
      ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .fm_v   (h_fm_v[n]),
        .fm_d   (h_fm_d[n]),
        .kv_v   (h_kv_v[n]),
        .kv_tag (h_kv_tag[n]),
        .kv_idx (h_kv_idx[n]),
        .kv_d   (h_kv_d[n]),
        .tok    (swap_at[n]),
        .res_v  (c_res_v[n]),
        .res_d  (c_res_d[n]),
        .sel_o  (core_sel[n]),
        .full_o (core_full[n])
      );

      wcd_align #(.DEPTH(NUM_CORES - 1 - n), .W(ACC_W)) u_align (
        .clk   (clk),
        .rst_n (rst_n),
        .in_v  (c_res_v[n]),
        .in_d  (c_res_d[n]),
        .out_v (a_res_v[n]),
        .out_d (res_data[n*ACC_W +: ACC_W])
      );
    end
  endgenerate

  assign res_valid = a_res_v[0];

endmodule

// File: rtl/wcd_checker.sv
module wcd_checker #(
  parameter int NUM_CORES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 batch_start,
  input logic                 stall,
  input logic                 swap_issue,
  input logic                 all_full,
  input logic [NUM_CORES-1:0] swap_at,
  input logic [NUM_CORES-1:0] core_sel,
  input logic                 tail_fm_valid,
  input logic                 res_valid
);

  // R6: a swap is only granted when every shadow bank is complete.
  p_issue_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    swap_issue |-> all_full);

  // R7: a request against an incomplete shadow set raises stall next cycle.
  p_stall_on_incomplete_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (batch_start && !all_full) |=> stall);

  // R7: once granted, the stall flag drops.
  p_stall_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swap_issue |=> !stall);

  // R9: at most one swap marker travels the chain.
  p_single_wave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(swap_at));

  // R5: bank selection only changes where the marker sits.
  p_sel_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|swap_at) |=> $stable(core_sel));

  // R4: the output appears exactly one cycle after the last core sees a feature.
  p_tail_to_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tail_fm_valid |=> res_valid);

  p_out_from_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(tail_fm_valid));

endmodule

bind conv_weight_chain wcd_checker #(.NUM_CORES(NUM_CORES)) u_wcd_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .batch_start   (batch_start),
  .stall         (stall),
  .swap_issue    (swap_issue),
  .all_full      (all_full),
  .swap_at       (swap_at),
  .core_sel      (core_sel),
  .tail_fm_valid (tail_fm_valid),
  .res_valid     (res_valid)
);

// File: tb/test_conv_weight_chain.sv
module test_conv_weight_chain;

  localparam int K     = 4;
  localparam int L     = 4;
  localparam int DW    = 8;
  localparam int AW    = 18;   // 2*8 + 2 from R3
  localparam int TW    = 2;
  localparam int IW    = 2;
  localparam int CLK_P = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            fm_valid = 1'b0;
  logic [L*DW-1:0] fm_data = '0;
  logic            kv_valid = 1'b0;
  logic [TW-1:0]   kv_tag = '0;
  logic [IW-1:0]   kv_idx = '0;
  logic [DW-1:0]   kv_data = '0;
  logic            batch_start = 1'b0;
  logic            stall;
  logic            res_valid;
  logic [K*AW-1:0] res_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int act [K][L];
  int shd [K][L];

  always #(CLK_P/2) clk = ~clk;

  conv_weight_chain #(.NUM_CORES(K), .VEC_LEN(L), .DATA_W(DW)) i_conv_weight_chain (
    .clk (clk), .rst_n (rst_n),
    .fm_valid (fm_valid), .fm_data (fm_data),
    .kv_valid (kv_valid), .kv_tag (kv_tag), .kv_idx (kv_idx), .kv_data (kv_data),
    .batch_start (batch_start), .stall (stall),
    .res_valid (res_valid), .res_data (res_data)
  );

  task automatic chk(input bit ok, input string req, input int actv, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actv, expv);
    end
  endtask

  function automatic int core_out(input int n);
    logic signed [AW-1:0] v;
    v = res_data[n*AW +: AW];
    return int'(v);
  endfunction

  function automatic int dot_ref(input int f[L], input int w[L]);
    int s = 0;
    for (int i = 0; i < L; i++) s += f[i] * w[i];
    return s;
  endfunction

  function automatic logic [L*DW-1:0] pack(input int f[L]);
    logic [L*DW-1:0] v;
    for (int i = 0; i < L; i++) v[i*DW +: DW] = DW'(f[i]);
    return v;
  endfunction

  // Checks the output word at the current sampling point against a model bank.
  task automatic check_out(input int f[L], input bit use_shd, input string req);
    chk(res_valid == 1'b1, {req, " res_valid"}, int'(res_valid), 1);
    for (int n = 0; n < K; n++) begin
      int e = dot_ref(f, use_shd ? shd[n] : act[n]);
      chk(core_out(n) == e, $sformatf("%s core%0d", req, n), core_out(n), e);
    end
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic send_feature(input int f[L], input bit use_shd, input string req);
    @(negedge clk); fm_valid = 1'b1; fm_data = pack(f);
    @(negedge clk); fm_valid = 1'b0;
    repeat (K) @(posedge clk);
    @(negedge clk);
    check_out(f, use_shd, req);
  endtask

  function automatic int kval(input int base, input int c, input int i);
    return ((base * 5 + c * 11 + i * 3) % 41) - 20;
  endfunction

  // Loads every core's shadow bank, elements in descending order.
  task automatic load_words(input int base, input bit konst, input int kv, input bit skip_last);
    for (int c = 0; c < K; c++)
      for (int i = L - 1; i >= 0; i--) begin
        if (!(skip_last && c == K - 1 && i == 0)) begin
          int v = konst ? kv : kval(base, c, i);
          @(negedge clk);
          kv_valid = 1'b1; kv_tag = TW'(c); kv_idx = IW'(i); kv_data = DW'(v);
          shd[c][i] = v;
        end
      end
    @(negedge clk); kv_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); batch_start = 1'b1;
    @(negedge clk); batch_start = 1'b0;
  endtask

  task automatic take_shadow();
    for (int c = 0; c < K; c++)
      for (int i = 0; i < L; i++) act[c][i] = shd[c][i];
  endtask

  task automatic t_reset();
    int f[L] = '{3, -4, 5, 6};
    chk(stall == 1'b0, "R1 stall after reset", int'(stall), 0);
    chk(res_valid == 1'b0, "R1 res_valid after reset", int'(res_valid), 0);
    // R4 latency: not valid after K edges, valid after K+1
    @(negedge clk); fm_valid = 1'b1; fm_data = pack(f);
    @(negedge clk); fm_valid = 1'b0;
    repeat (K - 1) @(posedge clk);
    @(negedge clk);
    chk(res_valid == 1'b0, "R4 early valid", int'(res_valid), 0);
    @(posedge clk); @(negedge clk);
    check_out(f, 1'b0, "R1 zero banks R4 latency");
    @(negedge clk);
    chk(res_valid == 1'b0, "R4 single output", int'(res_valid), 0);
  endtask

  task automatic t_load_swap();
    int f[L] = '{7, -2, 1, 4};
    load_words(1, 1'b0, 0, 1'b0);
    idle(K + 1);
    send_feature(f, 1'b0, "R5 before swap");
    pulse_start();
    chk(stall == 1'b0, "R6 granted start no stall", int'(stall), 0);
    take_shadow();
    idle(K + 2);
    send_feature(f, 1'b0, "R2 R3 after swap");
  endtask

  task automatic t_stream();
    int f0[L] = '{1, 2, 3, 4};
    int f1[L] = '{-5, 9, 0, -1};
    int f2[L] = '{12, -7, 8, 2};
    @(negedge clk); fm_valid = 1'b1; fm_data = pack(f0);
    @(negedge clk); fm_data = pack(f1);
    @(negedge clk); fm_data = pack(f2);
    @(negedge clk); fm_valid = 1'b0;
    repeat (K - 2) @(posedge clk);
    @(negedge clk); check_out(f0, 1'b0, "R4 stream 0");
    @(negedge clk); check_out(f1, 1'b0, "R4 stream 1");
    @(negedge clk); check_out(f2, 1'b0, "R4 stream 2");
    @(negedge clk);
    chk(res_valid == 1'b0, "R4 stream end", int'(res_valid), 0);
  endtask

  task automatic t_shadow_and_boundary();
    int fa[L] = '{2, 2, -3, 5};
    int fb[L] = '{-6, 1, 4, 9};
    load_words(2, 1'b0, 0, 1'b0);
    idle(K + 1);
    send_feature(fa, 1'b0, "R5 loaded shadow unused");
    // fa one cycle before the granted pulse, fb in the same cycle
    @(negedge clk); fm_valid = 1'b1; fm_data = pack(fa);
    @(negedge clk); fm_data = pack(fb); batch_start = 1'b1;
    @(negedge clk); fm_valid = 1'b0; batch_start = 1'b0;
    chk(stall == 1'b0, "R6 no stall when full", int'(stall), 0);
    repeat (K - 1) @(posedge clk);
    @(negedge clk); check_out(fa, 1'b0, "R6 before pulse old");
    @(negedge clk); check_out(fb, 1'b1, "R6 with pulse new");
    take_shadow();
    idle(K + 2);
  endtask

  task automatic t_stall();
    int f[L] = '{-3, 8, 6, -1};
    int waited = 0;
    load_words(3, 1'b0, 0, 1'b1);
    idle(K + 1);
    pulse_start();
    chk(stall == 1'b1, "R7 stall raised", int'(stall), 1);
    idle(6);
    chk(stall == 1'b1, "R7 stall held", int'(stall), 1);
    // R8: feature and the missing kernel word in the same cycle
    @(negedge clk);
    fm_valid = 1'b1; fm_data = pack(f);
    kv_valid = 1'b1; kv_tag = TW'(K - 1); kv_idx = '0; kv_data = DW'(kval(3, K - 1, 0));
    shd[K-1][0] = kval(3, K - 1, 0);
    @(negedge clk); fm_valid = 1'b0; kv_valid = 1'b0;
    repeat (K) @(posedge clk);
    @(negedge clk);
    check_out(f, 1'b0, "R8 feature during stall old");
    while (stall && waited < 20) begin
      @(negedge clk); waited++;
    end
    chk(stall == 1'b0, "R7 R8 stall released after fill", int'(stall), 0);
    take_shadow();
    idle(K + 2);
    send_feature(f, 1'b0, "R7 new kernels after release");
  endtask

  task automatic t_extremes();
    int fn[L] = '{-128, -128, -128, -128};
    int fp[L] = '{127, 127, 127, 127};
    load_words(0, 1'b1, -128, 1'b0);
    idle(K + 1);
    pulse_start();
    chk(stall == 1'b0, "R6 extreme swap granted", int'(stall), 0);
    take_shadow();
    idle(K + 2);
    send_feature(fn, 1'b0, "R3 max positive");
    chk(core_out(0) == 65536, "R3 no wrap +65536", core_out(0), 65536);
    send_feature(fp, 1'b0, "R3 max negative");
    chk(core_out(K - 1) == -65024, "R3 no wrap -65024", core_out(K - 1), -65024);
  endtask

  task automatic t_empty_reswap();
    int f[L] = '{1, -1, 2, -2};
    int waited = 0;
    pulse_start();
    chk(stall == 1'b1, "R9 empty shadow stalls", int'(stall), 1);
    idle(8);
    chk(stall == 1'b1, "R9 still stalled", int'(stall), 1);
    send_feature(f, 1'b0, "R9 active unchanged");
    load_words(4, 1'b0, 0, 1'b0);
    while (stall && waited < 20) begin
      @(negedge clk); waited++;
    end
    chk(stall == 1'b0, "R9 reload releases", int'(stall), 0);
    take_shadow();
    idle(K + 2);
    send_feature(f, 1'b0, "R9 reloaded kernels");
  endtask

  initial begin
    for (int c = 0; c < K; c++)
      for (int i = 0; i < L; i++) begin
        act[c][i] = 0;
        shd[c][i] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_swap();
    t_stream();
    t_shadow_and_boundary();
    t_stall();
    t_extremes();
    t_empty_reswap();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule